// File: doc/BRIEF.md
# Mailbox receive outbox FIFO

This block queues messages that remote cores send to the local processor. A remote producer pushes an entry through a single-cycle push port. Each entry carries a 64-bit payload and the number of the channel it came from. The local processor reaches the queue over a simple word-addressed register bus. It reads the oldest entry as two 32-bit payload words plus its channel number, then discards that entry by writing a trigger register.

The processor works out how many entries are queued from the raw write and read pointers and a full flag in the status register, and reads the capacity from a depth register. A level-style not-empty interrupt has a mask bit and a write-one-to-clear status bit, so the usual handler drains the whole queue and then clears the status. Writing zero to the reset register returns the queue to empty.

Top module: `mbx_rx_fifo`

## Requirements
- R1: Reading offset 0x04 returns payload bits 31:0 of the head entry, 0x08 returns payload bits 63:32, and 0x00 returns the head's channel number in bits 2:0 with the upper bits zero.
- R2: A write to offset 0x0C with bit 0 set removes the head entry when the FIFO is not empty. A write with bit 0 clear changes nothing.
- R3: A push while the FIFO holds DEPTH entries is dropped, and the DEPTH stored entries come out in arrival order.
- R4: A pop while the FIFO is empty leaves both pointers unchanged.
- R5: Status (0x14) holds the read pointer in bits 31:24, the write pointer in bits 23:16 and the full flag in bit 2, and all other bits are zero. Both pointers count modulo DEPTH, and the full flag means the two pointers are equal and DEPTH entries are held.
- R6: Offset 0x24 reads DEPTH-1.
- R7: IRQ status bit 0 (0x18) and the irq output become 1 one cycle after the FIFO is non-empty while mask bit 0 is clear.
- R8: Writing 1 to bit 0 of 0x18 clears the IRQ status. If entries remain, it sets again on the following cycle.
- R9: The mask register (0x1C, bits 4:0) resets to 5'h1F and reads back what was written. While mask bit 0 is set, the IRQ status does not become 1.
- R10: Writing 0 to offset 0x10 empties the FIFO and clears the pointers, the full flag and the IRQ status. A nonzero write there is ignored.
- R11: After reset both pointers are 0, the FIFO is empty, the IRQ status and irq are 0, and the mask is 5'h1F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_en | input | 1 | Enqueue request from the remote side |
| push_msg | input | 64 | Payload to enqueue |
| push_id | input | ID_W | Source channel of the payload |
| bus_addr | input | 6 | Byte offset of the register accessed |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| irq | output | 1 | Not-empty interrupt |

## Verification
The assertions check on every cycle that a push into a full queue leaves the write pointer unchanged and that a pop from an empty queue leaves the read pointer unchanged. They also check that the full flag only appears with equal pointers, that the interrupt only rises after an unmasked non-empty cycle, that a set mask keeps it low, and that the reset register empties everything in one cycle. Only the bench's scenarios can show the payload ordering across a pointer wrap, the register layout and the depth value. The same goes for the clear-then-reassert sequence of the interrupt and the fact that nonzero reset writes and zero trigger writes are ignored.

// File: rtl/mbx_rx_fifo.sv
module mbx_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int ID_W  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_en,
  input  logic [63:0]     push_msg,
  input  logic [ID_W-1:0] push_id,
  input  logic [5:0]      bus_addr,
  input  logic            bus_wr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            irq
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [5:0] A_ID = 6'h00, A_LO = 6'h04, A_HI = 6'h08, A_TRIG = 6'h0C,
                         A_RST = 6'h10, A_STS = 6'h14, A_ISTS = 6'h18, A_MASK = 6'h1C,
                         A_DEPTH = 6'h24;

  logic [63:0]     msg_mem [DEPTH];
  logic [ID_W-1:0] id_mem  [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic            full_q, irq_sts;
  logic [4:0]      mask_q;

  wire empty    = (wr_ptr == rd_ptr) && !full_q;
  wire fifo_clr = bus_wr && bus_addr == A_RST && bus_wdata == 32'd0;
  wire pop_req  = bus_wr && bus_addr == A_TRIG && bus_wdata[0];
  wire irq_clr  = bus_wr && bus_addr == A_ISTS && bus_wdata[0];
  wire do_push  = push_en && !full_q && !fifo_clr;
  wire do_pop   = pop_req && !empty && !fifo_clr;
  wire [AW-1:0] wr_nxt = wr_ptr + 1'b1;
  wire [AW-1:0] rd_nxt = rd_ptr + 1'b1;

  always_ff @(posedge clk)
    if (do_push) begin
      msg_mem[wr_ptr] <= push_msg;
      id_mem[wr_ptr]  <= push_id;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      full_q <= 1'b0;
    end else if (fifo_clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      full_q <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= wr_nxt;
      if (do_pop)  rd_ptr <= rd_nxt;
      if (do_push && !do_pop && wr_nxt == rd_ptr) full_q <= 1'b1;
      else if (do_pop && !do_push)                full_q <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          irq_sts <= 1'b0;
    else if (fifo_clr || irq_clr)        irq_sts <= 1'b0;
    else if (!empty && !mask_q[0])       irq_sts <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                 mask_q <= 5'h1F;
    else if (bus_wr && bus_addr == A_MASK)      mask_q <= bus_wdata[4:0];

  assign irq = irq_sts;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_ID:    bus_rdata = 32'(id_mem[rd_ptr]);
      A_LO:    bus_rdata = msg_mem[rd_ptr][31:0];
      A_HI:    bus_rdata = msg_mem[rd_ptr][63:32];
      A_STS:   bus_rdata = {8'(rd_ptr), 8'(wr_ptr), 13'd0, full_q, 2'd0};
      A_ISTS:  bus_rdata = {31'd0, irq_sts};
      A_MASK:  bus_rdata = {27'd0, mask_q};
      A_DEPTH: bus_rdata = 32'(DEPTH - 1);
      default: bus_rdata = '0;
    endcase
  end
endmodule

module mbx_rx_fifo_chk #(parameter int AW = 3) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_en,
  input logic          pop_req,
  input logic          fifo_clr,
  input logic [AW-1:0] wr_ptr,
  input logic [AW-1:0] rd_ptr,
  input logic          full_q,
  input logic          mask0,
  input logic          irq
);
  wire empty = (wr_ptr == rd_ptr) && !full_q;

  a_r3_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    push_en && full_q && !fifo_clr |=> $stable(wr_ptr));
  a_r4_pop_empty_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req && empty && !fifo_clr |=> $stable(rd_ptr));
  a_r5_full_equal_ptrs: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> wr_ptr == rd_ptr);
  a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(!empty && !mask0));
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mask0 && !irq |=> !irq);
  a_r10_fifo_clear: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> wr_ptr == '0 && rd_ptr == '0 && !full_q && !irq);
endmodule

bind mbx_rx_fifo mbx_rx_fifo_chk #(.AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .push_en(push_en), .pop_req(pop_req),
  .fifo_clr(fifo_clr), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .full_q(full_q),
  .mask0(mask_q[0]), .irq(irq)
);

// File: tb/mbx_rx_fifo_test.sv
module mbx_rx_fifo_test;
  localparam int DEPTH = 8;
  logic clk = 0, rst_n = 0, push_en = 0, bus_wr = 0;
  logic [63:0] push_msg = '0;
  logic [2:0]  push_id = '0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [66:0] model[$];

  always #2.5 clk = ~clk;

  mbx_rx_fifo #(.DEPTH(DEPTH), .ID_W(3)) uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_wr = 0; #1 v = bus_rdata;
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic push(logic [63:0] m, logic [2:0] id);
    @(negedge clk); push_en = 1; push_msg = m; push_id = id;
    @(negedge clk); push_en = 0;
    if (model.size() < DEPTH) model.push_back({id, m});
  endtask

  task automatic pop_check(string req);
    logic [31:0] v;
    logic [66:0] e = model.pop_front();
    rd(6'h04, v); chk({req, " R1 low"}, v, e[31:0]);
    rd(6'h08, v); chk({req, " R1 high"}, v, e[63:32]);
    rd(6'h00, v); chk({req, " R1 id"}, v, {29'd0, e[66:64]});
    wr(6'h0C, 32'd1);
  endtask

  task automatic sts(string req, int r, int w, bit f);
    logic [31:0] v;
    rd(6'h14, v); chk(req, v, {8'(r), 8'(w), 13'd0, f, 2'd0});
  endtask

  task automatic t_reset;
    logic [31:0] v;
    sts("R11 status", 0, 0, 0);
    chk("R11 irq", {31'd0, irq}, 0);
    rd(6'h1C, v); chk("R11 mask", v, 32'h1F);
    rd(6'h18, v); chk("R11 irq status", v, 0);
    rd(6'h24, v); chk("R6 depth", v, DEPTH - 1);
  endtask

  task automatic t_basic;
    push(64'h1111_2222_3333_4444, 3'd5);
    push(64'hDEAD_BEEF_0BAD_F00D, 3'd0);
    push(64'h0123_4567_89AB_CDEF, 3'd7);
    sts("R5 after three pushes", 0, 3, 0);
    wr(6'h0C, 32'd0);
    sts("R2 trigger zero ignored", 0, 3, 0);
    pop_check("R2 basic"); pop_check("R2 basic"); pop_check("R2 basic");
    sts("R2 drained", 3, 3, 0);
  endtask

  task automatic t_full;
    for (int i = 0; i < DEPTH + 1; i++) push({32'hA5A5_0000 + i, 32'h0F0F_0000 + i}, 3'(i));
    sts("R3 full flag", 3, 3, 1);
    for (int i = 0; i < 3; i++) pop_check("R3 order");
    sts("R5 wrap pointers", 6, 3, 0);
    for (int i = 0; i < DEPTH - 3; i++) pop_check("R3 order");
    sts("R3 ninth push dropped", 3, 3, 0);
  endtask

  task automatic t_empty_pop;
    wr(6'h0C, 32'd1);
    sts("R4 empty pop ignored", 3, 3, 0);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(6'h1C, 32'h1E);
    rd(6'h1C, v); chk("R9 mask readback", v, 32'h1E);
    push(64'h1, 3'd1); push(64'h2, 3'd2);
    rd(6'h18, v); chk("R7 irq status set", v, 1);
    chk("R7 irq pin", {31'd0, irq}, 1);
    wr(6'h18, 32'd1);
    chk("R8 cleared", {31'd0, irq}, 0);
    @(negedge clk);
    chk("R8 reasserts", {31'd0, irq}, 1);
    pop_check("R8 drain"); pop_check("R8 drain");
    wr(6'h18, 32'd1);
    repeat (3) @(negedge clk);
    chk("R8 stays clear when empty", {31'd0, irq}, 0);
    wr(6'h1C, 32'h1F);
    push(64'h3, 3'd3);
    repeat (3) @(negedge clk);
    chk("R9 masked irq", {31'd0, irq}, 0);
    rd(6'h18, v); chk("R9 masked status", v, 0);
  endtask

  task automatic t_fifo_rst;
    logic [31:0] v;
    wr(6'h1C, 32'h00);
    repeat (2) @(negedge clk);
    wr(6'h10, 32'd5);
    sts("R10 nonzero write ignored", 5, 6, 0);
    wr(6'h10, 32'd0);
    model.delete();
    sts("R10 pointers cleared", 0, 0, 0);
    chk("R10 irq cleared", {31'd0, irq}, 0);
    rd(6'h18, v); chk("R10 irq status", v, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset(); t_basic(); t_full(); t_empty_pop(); t_irq(); t_fifo_rst();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule